// File: doc/BRIEF.md
# Quadrature Encoder Input Decoder with Prescaled Noise Filter

This block sits in front of a position counter core, one instance per encoder channel. It takes the raw encoder lines A, B and Index and synchronizes each one. A digital filter then removes glitches from each line. The filter runs from a programmable 8-bit prescaled tick. From the clean levels the block produces one-cycle count strobes with a direction bit, in a pulse/direction function or in one of three quadrature resolutions (×1, ×2, ×4).

It also keeps a direction status bit and a sticky noise-error flag. It produces an index event that can be aligned to count edges. Configuration arrives as plain register fields and one-cycle command strobes from a neighbouring register block. The counter arithmetic, the host bus and interrupt handling live elsewhere.

Top module: `quad_decoder_fe`

## Requirements
- R1: With `fn_sel` = 2'b00 (pulse/direction), each rising edge of filtered A gives one `cnt_en` strobe, with `cnt_up` = 1 when B is 1 and 0 when B is 0. Falling edges of A and all edges of B give no strobe.
- R2: With `fn_sel` = 2'b01 (×1), one strobe is issued per full quadrature cycle. A rising edge of A while B = 0 counts up, and a falling edge of A while B = 0 counts down. A leading B (sequence AB = 00, 10, 11, 01) is the forward direction.
- R3: With `fn_sel` = 2'b10 (×2), every edge of A gives a strobe, up when moving forward and down when moving backward.
- R4: With `fn_sel` = 2'b11 (×4), every edge of A and every edge of B gives a strobe, up when forward and down when backward.
- R5: In any quadrature function, a sample in which filtered A and filtered B both change gives no strobe and sets `noise_err`.
- R6: A filtered line takes a new level only after the synchronized input has shown that level on two consecutive filter ticks. A filter tick comes once every `psc_val`+1 clock cycles. A burst shorter than one tick never produces a strobe.
- R7: Two or more changes of synchronized A (or of synchronized B) between two filter ticks set `noise_err`. The flag stays set until an `err_clr` strobe.
- R8: `psc_val` is 0 after reset. It takes the value of `preset_lo` on a `psc_load` strobe and holds it otherwise.
- R9: `dir_up` is 1 after reset. In quadrature functions it follows the direction of every legal transition. In pulse/direction it takes the B level at each counted edge.
- R10: While `ab_en` is 0, no strobe is produced and `dir_up` does not change.
- R11: In non-synchronous index operation, `idx_evt` pulses once on the rising edge of filtered Index when `idx_pol` = 1, and once on its falling edge when `idx_pol` = 0.
- R12: `idx_sync_on` is set only by an `idx_cfg_wr` strobe with `idx_sync_req` = 1 while a quadrature function is selected. It is cleared whenever pulse/direction is selected, and it stays cleared after quadrature is selected again.
- R13: With `idx_sync_on` = 1, the index event is held back until the first count strobe during the active index level. It is issued at most once per active period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ab_en | input | 1 | Enables counting from A/B |
| fn_sel | input | 2 | Count function: 00 pulse/dir, 01 ×1, 10 ×2, 11 ×4 |
| idx_pol | input | 1 | Index active level (1 = high) |
| idx_cfg_wr | input | 1 | Strobe writing the synchronous-index request |
| idx_sync_req | input | 1 | Requested synchronous-index setting |
| psc_load | input | 1 | Strobe loading the filter prescaler |
| preset_lo | input | 8 | Low byte of the preset value, prescaler source |
| err_clr | input | 1 | Strobe clearing the noise-error flag |
| a_in | input | 1 | Raw encoder line A |
| b_in | input | 1 | Raw encoder line B |
| idx_in | input | 1 | Raw index line |
| cnt_en | output | 1 | One-cycle count strobe |
| cnt_up | output | 1 | Direction of the current strobe (1 = up) |
| dir_up | output | 1 | Direction status |
| noise_err | output | 1 | Sticky noise / illegal-transition flag |
| idx_evt | output | 1 | One-cycle index event |
| idx_sync_on | output | 1 | Effective synchronous-index mode |
| psc_val | output | 8 | Current prescaler value |

## Verification
A wrong decode table or a wrong direction term shows at once, because the net position summed from the strobes drifts from the expected value. The bench therefore compares the position after every single-line step, within a few cycles of the edge. A filter that passes short bursts, or counts toggles wrongly, shows as a stray strobe or a missing error flag within one burst. A stale synchronous-index bit shows on the next configuration change as a wrong `idx_sync_on` level, or as an index event issued one step early.

// File: rtl/qd_pkg.sv
package qd_pkg;

    typedef enum logic [1:0] {
        FN_PULSE_DIR = 2'b00,
        FN_QUAD_X1   = 2'b01,
        FN_QUAD_X2   = 2'b10,
        FN_QUAD_X4   = 2'b11
    } qd_fn_e;

    typedef struct packed {
        logic a;
        logic b;
    } ab_t;

    typedef struct packed {
        logic cnt;      // produce a count strobe
        logic up;       // strobe direction
        logic dir_set;  // update direction status
        logic dir_val;  // new direction status
        logic illegal;  // both lines changed together
    } step_t;

    // Decode one sample-to-sample change of the filtered lines.
    function automatic step_t qd_step(qd_fn_e fn, ab_t prev, ab_t cur);
        step_t s;
        logic da, db, fwd;
        da  = prev.a ^ cur.a;
        db  = prev.b ^ cur.b;
        // forward: A leads B
        fwd = da ? (cur.a != cur.b) : (cur.b == cur.a);
        s = '0;
        if (fn == FN_PULSE_DIR) begin
            s.cnt     = da & cur.a;
            s.up      = cur.b;
            s.dir_set = da & cur.a;
            s.dir_val = cur.b;
        end else begin
            s.illegal = da & db;
            s.dir_set = da ^ db;
            s.dir_val = fwd;
            s.up      = fwd;
            unique case (fn)
                FN_QUAD_X1: begin
                    s.cnt = da & ~db & ~cur.b;
                    s.up  = cur.a;
                end
                FN_QUAD_X2: s.cnt = da & ~db;
                default:    s.cnt = da ^ db;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/qd_prescaler.sv
module qd_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PSC_W-1:0] load_val,
    output logic [PSC_W-1:0] psc_val,
    output logic             tick
);
    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] div_q;

    assign tick    = (div_q == psc_q);
    assign psc_val = psc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_q <= '0;
            div_q <= '0;
        end else begin
            if (load) psc_q <= load_val;
            if (tick || load) div_q <= '0;
            else              div_q <= div_q + 1'b1;
        end
    end

    AST_PSC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(psc_val)); // R8

endmodule

// File: rtl/qd_input_filter.sv
module qd_input_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int TOG_W       = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw,
    output logic filt,
    output logic noise
);
    localparam logic [TOG_W:0] NOISE_LIM = (TOG_W+1)'(2);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   s, s_prev, samp_q, filt_q, noise_q, toggle;
    logic [TOG_W-1:0]       tog_q;
    logic [TOG_W:0]         tog_sum;

    assign s       = sync_q[SYNC_STAGES-1];
    assign toggle  = s ^ s_prev;
    assign tog_sum = {1'b0, tog_q} + {{TOG_W{1'b0}}, toggle};
    assign filt    = filt_q;
    assign noise   = noise_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= raw;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            s_prev  <= 1'b0;
            samp_q  <= 1'b0;
            filt_q  <= 1'b0;
            noise_q <= 1'b0;
            tog_q   <= '0;
        end else begin
            s_prev  <= s;
            noise_q <= 1'b0;
            if (tick) begin
                samp_q  <= s;
                if (s == samp_q && s != filt_q) filt_q <= s;
                noise_q <= (tog_sum >= NOISE_LIM);
                tog_q   <= '0;
            end else if (toggle && tog_q != '1) begin
                tog_q <= tog_q + 1'b1;
            end
        end
    end

    AST_FILT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> $past(tick)); // R6

endmodule

// File: rtl/qd_step_decoder.sv
module qd_step_decoder
    import qd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  qd_fn_e fn,
    input  ab_t    ab,
    output logic   cnt_en,
    output logic   cnt_up,
    output logic   dir_up,
    output logic   illegal
);
    ab_t   prev_q;
    step_t st;

    assign st = qd_step(fn, prev_q, ab);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            cnt_en  <= 1'b0;
            cnt_up  <= 1'b0;
            dir_up  <= 1'b1;
            illegal <= 1'b0;
        end else begin
            prev_q  <= ab;
            cnt_en  <= enable & st.cnt;
            cnt_up  <= st.up;
            illegal <= enable & st.illegal;
            if (enable && st.dir_set) dir_up <= st.dir_val;
        end
    end

    AST_NO_CNT_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !cnt_en); // R10
    AST_DIR_HELD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(dir_up)); // R10

endmodule

// File: rtl/quad_decoder_fe.sv
module quad_decoder_fe
    import qd_pkg::*;
#(
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int N_LINES     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ab_en,
    input  logic [1:0]       fn_sel,
    input  logic             idx_pol,
    input  logic             idx_cfg_wr,
    input  logic             idx_sync_req,
    input  logic             psc_load,
    input  logic [PSC_W-1:0] preset_lo,
    input  logic             err_clr,
    input  logic             a_in,
    input  logic             b_in,
    input  logic             idx_in,
    output logic             cnt_en,
    output logic             cnt_up,
    output logic             dir_up,
    output logic             noise_err,
    output logic             idx_evt,
    output logic             idx_sync_on,
    output logic [PSC_W-1:0] psc_val
);
    localparam int LN_A = 0;
    localparam int LN_B = 1;
    localparam int LN_I = 2;

    qd_fn_e             fn;
    logic               tick, illegal;
    logic [N_LINES-1:0] raw, filt, noise;
    logic               err_q, sync_q, idx_prev, armed_q, evt_q;
    logic               idx_edge, idx_active, fire;

    assign fn  = qd_fn_e'(fn_sel);
    assign raw = {idx_in, b_in, a_in};

    qd_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst(rst), .load(psc_load), .load_val(preset_lo),
        .psc_val(psc_val), .tick(tick)
    );

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_line
            qd_input_filter #(.SYNC_STAGES(SYNC_STAGES)) u_flt (
                .clk(clk), .rst(rst), .tick(tick), .raw(raw[i]),
                .filt(filt[i]), .noise(noise[i])
            );
        end
    endgenerate

    qd_step_decoder u_dec (
        .clk(clk), .rst(rst), .enable(ab_en), .fn(fn),
        .ab('{a: filt[LN_A], b: filt[LN_B]}),
        .cnt_en(cnt_en), .cnt_up(cnt_up), .dir_up(dir_up), .illegal(illegal)
    );

    // sticky error: setting wins over clearing
    always_ff @(posedge clk) begin
        if (rst)                                    err_q <= 1'b0;
        else if (noise[LN_A] || noise[LN_B] || illegal) err_q <= 1'b1;
        else if (err_clr)                           err_q <= 1'b0;
    end

    // synchronous-index mode, only while a quadrature function is selected
    always_ff @(posedge clk) begin
        if (rst)                     sync_q <= 1'b0;
        else if (fn == FN_PULSE_DIR) sync_q <= 1'b0;
        else if (idx_cfg_wr)         sync_q <= idx_sync_req;
    end

    assign idx_active = (filt[LN_I] == idx_pol);
    assign idx_edge   = idx_pol ? (filt[LN_I] & ~idx_prev) : (~filt[LN_I] & idx_prev);
    assign fire       = armed_q & cnt_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_prev <= 1'b0;
            armed_q  <= 1'b0;
            evt_q    <= 1'b0;
        end else begin
            idx_prev <= filt[LN_I];
            evt_q    <= sync_q ? fire : idx_edge;
            if (!idx_active)   armed_q <= 1'b0;
            else if (idx_edge) armed_q <= 1'b1;
            else if (fire)     armed_q <= 1'b0;
        end
    end

    assign noise_err   = err_q;
    assign idx_sync_on = sync_q;
    assign idx_evt     = evt_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        noise_err && !err_clr |=> noise_err); // R7
    AST_ILLEGAL_FLAGS: assert property (@(posedge clk) disable iff (rst)
        illegal |=> noise_err); // R5
    AST_SYNC_QUAD_ONLY: assert property (@(posedge clk) disable iff (rst)
        fn_sel == 2'b00 |=> !idx_sync_on); // R12
    AST_SYNC_EVT_ON_CNT: assert property (@(posedge clk) disable iff (rst)
        idx_sync_on && $stable(idx_sync_on) && idx_evt |-> $past(cnt_en)); // R13

endmodule

// File: tb/quad_decoder_fe_tb_top.sv
module quad_decoder_fe_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ab_en = 1'b1, idx_pol = 1'b1, idx_cfg_wr = 1'b0, idx_sync_req = 1'b0;
    logic [1:0] fn_sel = 2'b00;
    logic       psc_load = 1'b0, err_clr = 1'b0, a_in = 1'b0, b_in = 1'b0, idx_in = 1'b0;
    logic [7:0] preset_lo = 8'h00;
    logic       cnt_en, cnt_up, dir_up, noise_err, idx_evt, idx_sync_on;
    logic [7:0] psc_val;

    int n_vec = 0, n_bad = 0;
    int pos = 0, idx_cnt = 0;
    int exp_pos = 0, exp_dir = 1, hold = 12;
    logic ca = 1'b0, cb = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    quad_decoder_fe dut_i (
        .clk(clk), .rst(rst), .ab_en(ab_en), .fn_sel(fn_sel), .idx_pol(idx_pol),
        .idx_cfg_wr(idx_cfg_wr), .idx_sync_req(idx_sync_req), .psc_load(psc_load),
        .preset_lo(preset_lo), .err_clr(err_clr), .a_in(a_in), .b_in(b_in),
        .idx_in(idx_in), .cnt_en(cnt_en), .cnt_up(cnt_up), .dir_up(dir_up),
        .noise_err(noise_err), .idx_evt(idx_evt), .idx_sync_on(idx_sync_on),
        .psc_val(psc_val)
    );

    always @(negedge clk) begin
        if (!rst && cnt_en) pos = pos + (cnt_up ? 1 : -1);
        if (!rst && idx_evt) idx_cnt = idx_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected count delta for a single-line change (from the requirements)
    function automatic int exp_delta(input logic [1:0] fn, input logic pa, pb, na, nb);
        logic da, db, fwd;
        da  = pa ^ na;
        db  = pb ^ nb;
        fwd = da ? (na != nb) : (nb == na);
        case (fn)
            2'b00:   return (da && na) ? (nb ? 1 : -1) : 0;
            2'b01:   return (da && !nb) ? (na ? 1 : -1) : 0;
            2'b10:   return da ? (fwd ? 1 : -1) : 0;
            default: return (da || db) ? (fwd ? 1 : -1) : 0;
        endcase
    endfunction

    task automatic move(input logic na, input logic nb);
        logic fwd;
        int d;
        if (ab_en) begin
            d = exp_delta(fn_sel, ca, cb, na, nb);
            exp_pos += d;
            fwd = (ca ^ na) ? (na != nb) : (nb == na);
            if (fn_sel == 2'b00) begin
                if (d != 0) exp_dir = nb;
            end else exp_dir = fwd;
        end
        ca = na; cb = nb;
        a_in = na; b_in = nb;
        wait_cyc(hold);
    endtask

    task automatic fwd_cycle(input int dir);
        for (int k = 0; k < 4; k++) begin
            if (dir > 0) begin
                if (ca == cb) move(~ca, cb); else move(ca, ~cb);
            end else begin
                if (ca == cb) move(ca, ~cb); else move(~ca, cb);
            end
        end
    endtask

    task automatic load_psc(input logic [7:0] v);
        preset_lo = v; psc_load = 1'b1;
        wait_cyc(1);
        psc_load = 1'b0;
        hold = 4 * (int'(v) + 1) + 8;
        wait_cyc(2);
    endtask

    task automatic pulse_clr;
        err_clr = 1'b1; wait_cyc(1); err_clr = 1'b0; wait_cyc(2);
    endtask

    task automatic write_sync(input logic v);
        idx_sync_req = v; idx_cfg_wr = 1'b1; wait_cyc(1); idx_cfg_wr = 1'b0; wait_cyc(2);
    endtask

    task automatic set_idx(input logic v);
        idx_in = v; wait_cyc(hold);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(3);
        // reset state
        chk(psc_val == 8'h00, "R8 reset psc", psc_val, 0);
        chk(dir_up == 1'b1, "R9 reset dir", dir_up, 1);
        chk(noise_err == 1'b0, "R7 reset err", noise_err, 0);
        chk(idx_sync_on == 1'b0, "R12 reset sync", idx_sync_on, 0);

        // R8 prescaler load and hold
        preset_lo = 8'h5A; psc_load = 1'b1; wait_cyc(1); psc_load = 1'b0;
        preset_lo = 8'h11; wait_cyc(3);
        chk(psc_val == 8'h5A, "R8 load/hold", psc_val, 8'h5A);
        load_psc(8'h00);

        // R1 pulse/direction
        fn_sel = 2'b00;
        move(1'b0, 1'b1);
        for (int k = 0; k < 3; k++) begin move(1'b1, 1'b1); move(1'b0, 1'b1); end
        chk(pos == exp_pos && pos == 3, "R1 pd up", pos, exp_pos);
        move(1'b0, 1'b0);
        for (int k = 0; k < 2; k++) begin move(1'b1, 1'b0); move(1'b0, 1'b0); end
        chk(pos == exp_pos && pos == 1, "R1 pd down", pos, exp_pos);
        chk(dir_up == 1'b0, "R9 pd dir", dir_up, 0);

        // R2 x1
        fn_sel = 2'b01;
        fwd_cycle(1); fwd_cycle(1);
        chk(pos == exp_pos && pos == 3, "R2 x1 fwd", pos, exp_pos);
        chk(dir_up == 1'b1, "R9 x1 dir", dir_up, 1);
        fwd_cycle(-1);
        chk(pos == exp_pos && pos == 2, "R2 x1 back", pos, exp_pos);

        // R3 x2
        fn_sel = 2'b10;
        fwd_cycle(1);
        chk(pos == exp_pos && pos == 4, "R3 x2 fwd", pos, exp_pos);
        fwd_cycle(-1); fwd_cycle(-1);
        chk(pos == exp_pos && pos == 0, "R3 x2 back", pos, exp_pos);

        // R4 x4
        fn_sel = 2'b11;
        fwd_cycle(1); fwd_cycle(1);
        chk(pos == exp_pos && pos == 8, "R4 x4 fwd", pos, exp_pos);
        fwd_cycle(-1);
        chk(pos == exp_pos && pos == 4, "R4 x4 back", pos, exp_pos);
        chk(dir_up == 1'b0, "R9 x4 dir", dir_up, 0);

        // random single-line steps across all functions
        for (int s = 0; s < 400; s++) begin
            if (s % 25 == 0) fn_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 1) move(~ca, cb); else move(ca, ~cb);
            chk(pos == exp_pos, "R1/R2/R3/R4 random pos", pos, exp_pos);
            chk(int'(dir_up) == exp_dir, "R9 random dir", dir_up, exp_dir);
        end
        chk(noise_err == 1'b0, "R7 no err on clean steps", noise_err, 0);

        // R5 illegal transition
        fn_sel = 2'b11;
        ca = ~ca; cb = ~cb; a_in = ca; b_in = cb;
        wait_cyc(hold);
        chk(pos == exp_pos, "R5 illegal no count", pos, exp_pos);
        chk(noise_err == 1'b1, "R5 illegal sets err", noise_err, 1);
        wait_cyc(20);
        chk(noise_err == 1'b1, "R7 sticky", noise_err, 1);
        pulse_clr();
        chk(noise_err == 1'b0, "R7 cleared", noise_err, 0);

        // R10 gating
        ab_en = 1'b0;
        begin : gate
            int d0;
            d0 = int'(dir_up);
            for (int k = 0; k < 4; k++) begin
                if (d0 == 1) begin if (ca == cb) move(ca, ~cb); else move(~ca, cb); end
                else         begin if (ca == cb) move(~ca, cb); else move(ca, ~cb); end
            end
            chk(pos == exp_pos, "R10 no count disabled", pos, exp_pos);
            chk(int'(dir_up) == d0, "R10 dir held", dir_up, d0);
        end
        ab_en = 1'b1;
        fwd_cycle(1);
        chk(pos == exp_pos, "R10 re-enabled", pos, exp_pos);

        // R6 / R7 filter with prescaler 15
        load_psc(8'd15);
        begin : burst
            logic base_a;
            base_a = ca;
            for (int k = 0; k < 2; k++) begin
                a_in = ~base_a; wait_cyc(1);
                a_in = base_a;  wait_cyc(1);
            end
            wait_cyc(hold);
        end
        chk(pos == exp_pos, "R6 burst filtered", pos, exp_pos);
        chk(noise_err == 1'b1, "R7 burst noise", noise_err, 1);
        pulse_clr();
        fwd_cycle(1);
        chk(pos == exp_pos, "R6 slow steps pass", pos, exp_pos);
        chk(noise_err == 1'b0, "R7 slow steps clean", noise_err, 0);
        load_psc(8'd0);

        // R11 index polarity, non-synchronous
        idx_cnt = 0;
        idx_pol = 1'b1;
        set_idx(1'b1);
        set_idx(1'b0);
        chk(idx_cnt == 1, "R11 rising only", idx_cnt, 1);
        idx_pol = 1'b0;
        set_idx(1'b1);
        set_idx(1'b0);
        chk(idx_cnt == 2, "R11 falling only", idx_cnt, 2);

        // R12 synchronous mode restriction
        fn_sel = 2'b00;
        write_sync(1'b1);
        chk(idx_sync_on == 1'b0, "R12 refused in pd", idx_sync_on, 0);
        fn_sel = 2'b11; wait_cyc(2);
        write_sync(1'b1);
        chk(idx_sync_on == 1'b1, "R12 set in quad", idx_sync_on, 1);
        fn_sel = 2'b00; wait_cyc(2);
        chk(idx_sync_on == 1'b0, "R12 forced off", idx_sync_on, 0);
        fn_sel = 2'b11; wait_cyc(2);
        chk(idx_sync_on == 1'b0, "R12 stays off", idx_sync_on, 0);

        // R13 synchronous index event
        write_sync(1'b1);
        idx_pol = 1'b1;
        idx_cnt = 0;
        set_idx(1'b1);
        chk(idx_cnt == 0, "R13 held without count", idx_cnt, 0);
        if (ca == cb) move(~ca, cb); else move(ca, ~cb);
        chk(idx_cnt == 1, "R13 on count", idx_cnt, 1);
        if (ca == cb) move(~ca, cb); else move(ca, ~cb);
        chk(idx_cnt == 1, "R13 once per period", idx_cnt, 1);
        set_idx(1'b0);
        set_idx(1'b1);
        if (ca == cb) move(~ca, cb); else move(ca, ~cb);
        chk(idx_cnt == 2, "R13 next period", idx_cnt, 2);
        chk(pos == exp_pos, "R4 pos after index", pos, exp_pos);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule